// File: doc/BRIEF.md
# Integer Vector Across-Lanes Reduction Unit

This unit takes a 32-bit vector instruction word and a 128-bit source vector. It collapses every lane of the vector into a single scalar. Four reductions are provided: a modular sum, a widening sum, a maximum and a minimum. The last three each come in a signed and an unsigned form. The unit decodes the instruction fields itself. It rejects illegal encodings, sizes the lanes, extends each element to the accumulator width, folds one lane per clock, and fixes the width of the final value.

A caller presents the instruction and operand together with a one-cycle start strobe while the unit is idle. Some cycles later the unit raises a one-cycle done strobe, and the 64-bit result is valid in that cycle. The result then stays stable until the next operation completes. If the encoding is illegal, the unit raises done together with an undefined-instruction flag in the cycle after start, and the result is zero.

Top module: `simd_lane_reduce`

## Requirements
- R1: Fields are taken from the instruction as: operation code at bits 16:12, size at bits 23:22, unsigned flag at bit 29, full-width flag at bit 30. All other bits, including the register numbers at bits 9:0, have no effect on the result.
- R2: Operation code 0x1B is the modular sum and is legal only with the unsigned flag at 0. Code 0x03 is the widening sum, 0x0A is the maximum and 0x1A is the minimum; for these three the unsigned flag picks unsigned (1) or signed (0). Every other code is undefined.
- R3: An encoding with size 3, or with size 2 and the full-width flag at 0, is undefined.
- R4: The element width is 8 << size bits. The lane count is 128 divided by the element width when the full-width flag is 1, and 64 divided by it when the flag is 0. With the flag at 0, bits 127:64 of the source have no effect.
- R5: Each element is sign-extended when the unsigned flag is 0 and zero-extended when it is 1. The accumulator starts at lane 0, and lanes 1 through N-1 are folded in ascending order.
- R6: The modular sum returns the low element-width bits of the lane total, zero-extended to 64 bits.
- R7: The widening sum returns the low 2×element-width bits of the total of the extended lanes, zero-extended to 64 bits.
- R8: The maximum returns the largest lane and the minimum returns the smallest, using a signed or unsigned compare as the unsigned flag selects. The value is truncated to the element width and zero-extended.
- R9: For a legal encoding, done is high for exactly one cycle, N-1 clock edges after the edge that accepts start.
- R10: For an undefined encoding, done and the undefined flag are both high in the cycle after the accepting edge, and the result is zero.
- R11: A start strobe that arrives while a reduction is in progress is ignored. The running operation finishes unchanged, and no second operation follows.
- R12: After reset, done, the undefined flag and the result are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a reduction |
| insn_i | input | 32 | Instruction word, sampled with start |
| src_i | input | 128 | Source vector, sampled with start |
| result_o | output | 64 | Zero-extended scalar result |
| done_o | output | 1 | One-cycle completion strobe |
| undef_o | output | 1 | Undefined-encoding flag, valid with done |

## Verification
Some properties are checked by assertions on every cycle:
- done never follows a cycle in which the unit was idle unless the encoding was flagged undefined;
- an undefined flag always comes with done and a zero result, one edge after an illegal start;
- the lane index never passes the last lane;
- a start during a run leaves the latched decode unchanged;
- results of byte-sized operations carry no bits above their width.

Other behaviour only the bench scenarios can show:
- the arithmetic values;
- the ordering of signed against unsigned compares on the extreme lane patterns (most-negative, most-positive, all-ones, alternating);
- the exact latency for every legal size, width and signedness.

// File: rtl/lred_pkg.sv
package lred_pkg;

    typedef enum logic [1:0] {
        RED_SUM  = 2'd0,
        RED_WSUM = 2'd1,
        RED_MAX  = 2'd2,
        RED_MIN  = 2'd3
    } red_op_e;

    localparam logic [4:0] OPC_SUM  = 5'h1B;
    localparam logic [4:0] OPC_WSUM = 5'h03;
    localparam logic [4:0] OPC_MAX  = 5'h0A;
    localparam logic [4:0] OPC_MIN  = 5'h1A;

    typedef struct packed {
        red_op_e    op;
        logic       uns;
        logic [1:0] size;
        logic       full;
        logic       undef;
    } dec_t;

endpackage

// File: rtl/lred_decode.sv
module lred_decode
    import lred_pkg::*;
#(
    parameter int VEC_W = 128,
    parameter int CNT_W = 5
) (
    input  logic [31:0]      insn_i,
    output dec_t             dec_o,
    output logic [CNT_W-1:0] lanes_o
);

    logic [4:0] opc;
    logic [1:0] sz;
    logic       u;
    logic       q;
    logic       opc_ok;
    logic       size_bad;
    red_op_e    op;

    always_comb begin
        opc    = insn_i[16:12];
        sz     = insn_i[23:22];
        u      = insn_i[29];
        q      = insn_i[30];
        op     = RED_SUM;
        opc_ok = 1'b1;
        case (opc)
            OPC_SUM:  begin op = RED_SUM;  opc_ok = !u; end
            OPC_WSUM: op = RED_WSUM;
            OPC_MAX:  op = RED_MAX;
            OPC_MIN:  op = RED_MIN;
            default:  opc_ok = 1'b0;
        endcase
        size_bad = (sz == 2'd3) || (sz == 2'd2 && !q);

        dec_o.op    = op;
        dec_o.uns   = u;
        dec_o.size  = sz;
        dec_o.full  = q;
        dec_o.undef = !opc_ok || size_bad;

        lanes_o = (q ? CNT_W'(VEC_W / 8) : CNT_W'(VEC_W / 16)) >> sz;
    end

endmodule

// File: rtl/lred_lane_ext.sv
module lred_lane_ext #(
    parameter int VEC_W = 128,
    parameter int ACC_W = 64,
    parameter int IDX_W = 4
) (
    input  logic [VEC_W-1:0] vec_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [1:0]       size_i,
    input  logic             uns_i,
    output logic [ACC_W-1:0] elem_o
);

    localparam int SH_W = $clog2(VEC_W);

    logic [SH_W-1:0]  shamt;
    logic [VEC_W-1:0] shifted;
    logic [ACC_W-1:0] raw;
    logic [ACC_W-1:0] mask;
    logic [6:0]       ew;
    logic [5:0]       top_bit;
    logic             sign_bit;

    always_comb begin
        ew       = 7'd8 << size_i;
        shamt    = (SH_W'(idx_i) << 3) << size_i;
        shifted  = vec_i >> shamt;
        raw      = shifted[ACC_W-1:0];
        mask     = (ACC_W'(1) << ew) - ACC_W'(1);
        top_bit  = 6'(ew - 7'd1);
        sign_bit = raw[top_bit];
        elem_o   = (raw & mask) | ((sign_bit && !uns_i) ? ~mask : '0);
    end

endmodule

// File: rtl/lred_combine.sv
module lred_combine
    import lred_pkg::*;
#(
    parameter int ACC_W = 64
) (
    input  logic [ACC_W-1:0] acc_i,
    input  logic [ACC_W-1:0] elem_i,
    input  red_op_e          op_i,
    input  logic             uns_i,
    output logic [ACC_W-1:0] acc_o
);

    logic keep_ge;
    logic keep_le;

    always_comb begin
        keep_ge = uns_i ? (acc_i >= elem_i) : ($signed(acc_i) >= $signed(elem_i));
        keep_le = uns_i ? (acc_i <= elem_i) : ($signed(acc_i) <= $signed(elem_i));
        case (op_i)
            RED_MAX: acc_o = keep_ge ? acc_i : elem_i;
            RED_MIN: acc_o = keep_le ? acc_i : elem_i;
            default: acc_o = acc_i + elem_i;
        endcase
    end

endmodule

// File: rtl/simd_lane_reduce.sv
module simd_lane_reduce
    import lred_pkg::*;
#(
    parameter int VEC_W = 128,
    parameter int ACC_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [31:0]       insn_i,
    input  logic [VEC_W-1:0]  src_i,
    output logic [ACC_W-1:0]  result_o,
    output logic              done_o,
    output logic              undef_o
);

    localparam int LANES_MAX = VEC_W / 8;
    localparam int IDX_W     = $clog2(LANES_MAX);
    localparam int CNT_W     = $clog2(LANES_MAX + 1);
    localparam int HALF_W    = VEC_W / 2;

    typedef struct packed {
        logic             busy;
        dec_t             dec;
        logic [IDX_W-1:0] idx;
        logic [IDX_W-1:0] last;
        logic [VEC_W-1:0] vec;
        logic [ACC_W-1:0] acc;
        logic [ACC_W-1:0] result;
        logic             done;
        logic             undef;
    } state_t;

    state_t s_d, s_q;

    dec_t             dec;
    logic [CNT_W-1:0] lanes;
    logic [VEC_W-1:0] src_fit;
    logic [VEC_W-1:0] ext_vec;
    logic [IDX_W-1:0] ext_idx;
    logic [1:0]       ext_size;
    logic             ext_uns;
    logic [ACC_W-1:0] elem;
    logic [ACC_W-1:0] folded;

    lred_decode #(.VEC_W(VEC_W), .CNT_W(CNT_W)) u_decode (
        .insn_i  (insn_i),
        .dec_o   (dec),
        .lanes_o (lanes)
    );

    // One lane extractor, shared between seeding (idle) and folding (busy).
    always_comb begin
        src_fit  = dec.full ? src_i : {{HALF_W{1'b0}}, src_i[HALF_W-1:0]};
        ext_vec  = s_q.busy ? s_q.vec      : src_fit;
        ext_idx  = s_q.busy ? s_q.idx      : '0;
        ext_size = s_q.busy ? s_q.dec.size : dec.size;
        ext_uns  = s_q.busy ? s_q.dec.uns  : dec.uns;
    end

    lred_lane_ext #(.VEC_W(VEC_W), .ACC_W(ACC_W), .IDX_W(IDX_W)) u_lane (
        .vec_i  (ext_vec),
        .idx_i  (ext_idx),
        .size_i (ext_size),
        .uns_i  (ext_uns),
        .elem_o (elem)
    );

    lred_combine #(.ACC_W(ACC_W)) u_combine (
        .acc_i  (s_q.acc),
        .elem_i (elem),
        .op_i   (s_q.dec.op),
        .uns_i  (s_q.dec.uns),
        .acc_o  (folded)
    );

    function automatic logic [ACC_W-1:0] fit_width(input logic [ACC_W-1:0] v,
                                                   input logic [1:0] size,
                                                   input logic widen);
        logic [2:0] lg;
        lg = {1'b0, size} + {2'b00, widen};
        case (lg)
            3'd0:    return v & ((ACC_W'(1) << 8)  - ACC_W'(1));
            3'd1:    return v & ((ACC_W'(1) << 16) - ACC_W'(1));
            3'd2:    return v & ((ACC_W'(1) << 32) - ACC_W'(1));
            default: return v;
        endcase
    endfunction

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        s_d.undef = 1'b0;
        if (!s_q.busy) begin
            if (start_i) begin
                if (dec.undef) begin
                    s_d.done   = 1'b1;
                    s_d.undef  = 1'b1;
                    s_d.result = '0;
                end else begin
                    s_d.busy = 1'b1;
                    s_d.dec  = dec;
                    s_d.vec  = src_fit;
                    s_d.idx  = IDX_W'(1);
                    s_d.last = IDX_W'(lanes - CNT_W'(1));
                    s_d.acc  = elem;
                end
            end
        end else begin
            s_d.acc = folded;
            s_d.idx = s_q.idx + IDX_W'(1);
            if (s_q.idx == s_q.last) begin
                s_d.busy   = 1'b0;
                s_d.done   = 1'b1;
                s_d.result = fit_width(folded, s_q.dec.size, s_q.dec.op == RED_WSUM);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign result_o = s_q.result;
    assign done_o   = s_q.done;
    assign undef_o  = s_q.undef;

    // A regular completion must come out of a run in progress.
    assert_done_after_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !undef_o) |-> $past(s_q.busy));

    assert_undef_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        undef_o |-> (done_o && result_o == '0));

    assert_undef_next_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.busy && start_i && dec.undef) |=> (done_o && undef_o));

    assert_idx_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy |-> (s_q.idx <= s_q.last));

    assert_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && s_q.idx != s_q.last) |=> ($stable(s_q.dec) && s_q.busy));

    assert_byte_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !undef_o && s_q.dec.op != RED_WSUM && s_q.dec.size == 2'd0)
            |-> (result_o[ACC_W-1:8] == '0));

    assert_widen_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !undef_o && s_q.dec.op == RED_WSUM && s_q.dec.size == 2'd0)
            |-> (result_o[ACC_W-1:16] == '0));

endmodule

// File: tb/simd_lane_reduce_tb.sv
module simd_lane_reduce_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_r = 1'b0;
    logic [31:0]  insn_r = '0;
    logic [127:0] src_r = '0;
    logic [63:0]  result_o;
    logic         done_o;
    logic         undef_o;

    int total = 0;
    int fails = 0;

    always #10 clk = ~clk;   // 50 MHz

    simd_lane_reduce u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_r),
        .insn_i   (insn_r),
        .src_i    (src_r),
        .result_o (result_o),
        .done_o   (done_o),
        .undef_o  (undef_o)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Behavioural reference computed from the requirements.
    task automatic ref_model(input logic [31:0] insn, input logic [127:0] v,
                             output logic [63:0] res, output logic und, output int n);
        logic [4:0]  opc;
        logic [1:0]  sz;
        logic        u, q, ok;
        int          esize, rw;
        logic [63:0] mask, acc, e;
        opc = insn[16:12];
        sz  = insn[23:22];
        u   = insn[29];
        q   = insn[30];
        ok  = (opc == 5'h1B && !u) || opc == 5'h03 || opc == 5'h0A || opc == 5'h1A;
        und = !ok || sz == 2'd3 || (sz == 2'd2 && !q);
        res = '0;
        n   = 0;
        if (und) return;
        esize = 8 << sz;
        n     = (q ? 128 : 64) / esize;
        mask  = (64'd1 << esize) - 64'd1;
        acc   = '0;
        for (int i = 0; i < n; i++) begin
            e = 64'(v >> (i * esize)) & mask;
            if (!u && e[esize-1]) e = e | ~mask;
            if (i == 0) acc = e;
            else if (opc == 5'h0A) begin
                if (u) acc = (acc >= e) ? acc : e;
                else   acc = ($signed(acc) >= $signed(e)) ? acc : e;
            end else if (opc == 5'h1A) begin
                if (u) acc = (acc <= e) ? acc : e;
                else   acc = ($signed(acc) <= $signed(e)) ? acc : e;
            end else acc = acc + e;
        end
        rw  = (opc == 5'h03) ? 2 * esize : esize;
        res = (rw >= 64) ? acc : (acc & ((64'd1 << rw) - 64'd1));
    endtask

    function automatic logic [127:0] build_vec(input int kind, input int esize);
        logic [127:0] v;
        logic [63:0]  m, lane;
        m = (esize == 64) ? '1 : ((64'd1 << esize) - 64'd1);
        v = {$urandom, $urandom, $urandom, $urandom};
        if (kind == 0) return v;
        v = '0;
        for (int i = 0; i < 128 / esize; i++) begin
            case (kind)
                1:       lane = 64'd1 << (esize - 1);
                2:       lane = m >> 1;
                3:       lane = m;
                default: lane = (i % 2 == 1) ? (m >> 1) : (64'd1 << (esize - 1));
            endcase
            v = v | (128'(lane) << (i * esize));
        end
        return v;
    endfunction

    function automatic logic [31:0] make_insn(input logic [4:0] opc, input logic [1:0] sz,
                                              input logic u, input logic q);
        logic [31:0] w;
        w = $urandom;      // R1: unrelated bits random, incl. register numbers
        w[16:12] = opc;
        w[23:22] = sz;
        w[29]    = u;
        w[30]    = q;
        return w;
    endfunction

    // Issues one operation and watches done on every clock.
    task automatic do_run(input logic [31:0] insn, input logic [127:0] v, input string tag);
        logic [63:0] exp_res, got;
        logic        exp_und, gu;
        int          n, exp_k, seen;
        bit          extra;
        ref_model(insn, v, exp_res, exp_und, n);
        exp_k = exp_und ? 0 : n - 1;
        @(negedge clk);
        insn_r  = insn;
        src_r   = v;
        start_r = 1'b1;
        @(negedge clk);
        start_r = 1'b0;
        seen  = -1;
        extra = 1'b0;
        got   = '0;
        gu    = 1'b0;
        for (int k = 0; k <= exp_k + 3; k++) begin
            if (k > 0) @(negedge clk);
            if (done_o) begin
                if (seen < 0) begin seen = k; got = result_o; gu = undef_o; end
                else extra = 1'b1;
            end
        end
        chk(seen == exp_k && !extra, exp_und ? "R10 latency" : "R9 latency",
            64'(seen), 64'(exp_k));
        chk(got == exp_res, {tag, " result"}, got, exp_res);
        chk(gu == exp_und, "R2 R3 undef flag", 64'(gu), 64'(exp_und));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL R9 watchdog expired actual=hung expected=finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [4:0]   opcs [4];
        logic [31:0]  ia, ib;
        logic [127:0] va;
        logic [63:0]  ea;
        logic         ua;
        int           na, cnt;

        opcs[0] = 5'h1B; opcs[1] = 5'h03; opcs[2] = 5'h0A; opcs[3] = 5'h1A;

        repeat (3) @(negedge clk);
        // R12 reset values
        chk(done_o == 1'b0, "R12 done", 64'(done_o), 64'd0);
        chk(undef_o == 1'b0, "R12 undef", 64'(undef_o), 64'd0);
        chk(result_o == '0, "R12 result", result_o, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Every legal size / width / signedness / operation, five patterns each.
        for (int sz = 0; sz < 3; sz++)
            for (int q = 0; q < 2; q++)
                for (int o = 0; o < 4; o++)
                    for (int u = 0; u < 2; u++)
                        for (int kind = 0; kind < 5; kind++) begin
                            if (sz == 2 && q == 0) continue;
                            if (o == 0 && u == 1) continue;
                            do_run(make_insn(opcs[o], 2'(sz), 1'(u), 1'(q)),
                                   build_vec(kind, 8 << sz),
                                   $sformatf("R1 R5 %s%s", (o == 0) ? "R6" : (o == 1) ? "R7" : "R8",
                                             (q == 0) ? " R4" : ""));
                        end

        // Undefined encodings: R2 opcode cases, R3 size cases, R10 response.
        do_run(make_insn(5'h1B, 2'd0, 1'b1, 1'b1), '1, "R2 R10 sum with unsigned");
        do_run(make_insn(5'h05, 2'd0, 1'b0, 1'b1), '1, "R2 R10 unknown code");
        do_run(make_insn(5'h0C, 2'd2, 1'b1, 1'b1), '1, "R2 R10 unknown code");
        do_run(make_insn(5'h03, 2'd3, 1'b0, 1'b1), '1, "R3 R10 size 3");
        do_run(make_insn(5'h0A, 2'd2, 1'b0, 1'b0), '1, "R3 R10 size 2 half width");
        do_run(make_insn(5'h1A, 2'd3, 1'b1, 1'b0), '1, "R3 R10 size 3 half width");

        // R11: start pulses during a run are ignored.
        ia = make_insn(5'h03, 2'd0, 1'b0, 1'b1);
        va = build_vec(0, 8);
        ref_model(ia, va, ea, ua, na);
        ib = make_insn(5'h0A, 2'd1, 1'b1, 1'b1);
        @(negedge clk);
        insn_r = ia; src_r = va; start_r = 1'b1;
        @(negedge clk);
        insn_r = ib; src_r = ~va;
        cnt = 0;
        for (int k = 0; k < na + 20; k++) begin
            if (k > 0) @(negedge clk);
            if (k == 2) start_r = 1'b0;
            if (done_o) begin
                cnt++;
                if (cnt == 1) chk(result_o == ea, "R11 running result kept", result_o, ea);
            end
        end
        chk(cnt == 1, "R11 single completion", 64'(cnt), 64'd1);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule